// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block drives one output line with a burst of up to 32 pulses. Every pulse has its own high time and its own low time. Both come from a per-pulse configuration word in a bank that lives outside the block. A start strobe launches the burst. A pulse-count input sets how many pulses the burst holds. While the burst runs, the block shows the index of the pulse it is generating. It raises a one-cycle done strobe when the last low phase ends.

All durations are measured in ticks of a shared prescaler. A tick lasts `prescale + 1` clock cycles. The count and the prescale value are captured when the burst starts. A pulse's configuration word is captured when that pulse begins, so software may rewrite later words while the burst is running. An abort input or a synchronous reset returns the block to idle at once.

Top module: `pulse_train_gen`

## Requirements
- R1: After synchronous reset `rst`, `pulseOut`, `pulseIdx`, `done` and `busy` are all 0.
- R2: When `start` is sampled in idle with `pulseCount` N between 1 and 32, the burst emits exactly N pulses. `busy` is 1 throughout the burst. `pulseIdx` holds i, counting from 0, during both phases of pulse i.
- R3: Pulse i uses the word at `cfgWords[24*i+23 : 24*i]`. Its high time in ticks is bits [11:0] of that word. `pulseOut` rises on the clock edge that samples `start`, or on the edge that ends the previous low phase, and stays high for that many ticks.
- R4: The low phase of pulse i follows its high phase directly. Its length in ticks is bits [23:12] of the same word.
- R5: A high or low field of 0 gives a phase of 1 tick.
- R6: One tick is `prescale + 1` clock cycles. `prescale` and `pulseCount` are sampled only on the edge that starts the burst.
- R7: `done` is high for exactly one cycle, in the cycle after the last low phase ends. In that same cycle `busy` is 0 and `pulseIdx` is 0.
- R8: A start with `pulseCount` 0 emits no pulse. It raises `done` for one cycle in the next cycle and leaves `busy` at 0.
- R9: A `pulseCount` above 32 is treated as 32.
- R10: `start` has no effect while `busy` is 1.
- R11: `abort` forces idle on the next edge: `pulseOut` 0, `pulseIdx` 0, `busy` 0, and no `done`. An abort takes priority over a `start` in the same cycle.
- R12: A pulse's configuration word is sampled on the edge where that pulse begins. Changes to it after that edge do not affect the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch a burst when idle |
| abort | input | 1 | Stop the burst and return to idle |
| pulseCount | input | 6 | Number of pulses in the burst (0 to 63, clamped to 32) |
| prescale | input | 8 | Tick length minus one, in clock cycles |
| cfgWords | input | 768 | 32 words of 24 bits: low time in [23:12], high time in [11:0] |
| pulseOut | output | 1 | Generated pulse train |
| pulseIdx | output | 5 | Index of the pulse being generated |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle strobe at the end of a burst |

## Verification
The bench targets these corner cases, each with the failure it would catch:
- **One-cycle phases.** Zero-length fields and prescale 0 produce one-cycle phases. An off-by-one in the phase counter would show up here as a stretched or vanished phase.
- **Clamped count.** A count of 40 must give exactly 32 pulses. Missing clamping would run the index past the word bank.
- **Zero count.** A count of 0 must give a lone done strobe with no pulse.
- **Prescale and word sampling.** Prescale and configuration words are changed during a burst. A design that reads them live would shift the phase lengths in flight.
- **Start and abort.** A start while busy must be ignored. An abort, including an abort in the same cycle as a start, must leave the output low with no done strobe.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } ptg_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;        // a phase is being timed
    logic loadFirst;  // capture count, prescale and word 0
    logic loadNext;   // advance to next pulse, capture its word
    logic toLow;      // switch current pulse to its low phase
    logic clear;      // return datapath to idle values
  } ptg_strobe_t;

endpackage

// File: rtl/ptg_dpath.sv
module ptg_dpath
  import ptg_pkg::*;
#(
  parameter int NUM_PULSES = 32,
  parameter int DUR_W      = 12,
  parameter int PRESC_W    = 8,
  localparam int WORD_W    = 2 * DUR_W,
  localparam int IDX_W     = $clog2(NUM_PULSES),
  localparam int CNT_W     = $clog2(NUM_PULSES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  ptg_strobe_t                  strb,
  input  logic [CNT_W-1:0]             pulseCount,
  input  logic [PRESC_W-1:0]           prescale,
  input  logic [NUM_PULSES*WORD_W-1:0] cfgWords,
  output logic [IDX_W-1:0]             idx,
  output logic                         countZero,
  output logic                         phaseEnd,
  output logic                         lastPulse
);

  logic [DUR_W-1:0]   tonArr  [NUM_PULSES];
  logic [DUR_W-1:0]   toffArr [NUM_PULSES];

  for (genvar g = 0; g < NUM_PULSES; g++) begin : gSplit
    assign tonArr[g]  = cfgWords[g*WORD_W +: DUR_W];
    assign toffArr[g] = cfgWords[g*WORD_W + DUR_W +: DUR_W];
  end

  logic [DUR_W-1:0]   tonLat, toffLat, curLen, lenM1, durCnt;
  logic [PRESC_W-1:0] prescLat, preCnt;
  logic [CNT_W-1:0]   cntLat, cntClamp;
  logic [IDX_W-1:0]   nextIdx;
  logic               phaseHigh, tick;

  assign cntClamp  = (pulseCount > CNT_W'(NUM_PULSES)) ? CNT_W'(NUM_PULSES) : pulseCount;
  assign countZero = (pulseCount == '0);
  assign nextIdx   = strb.loadFirst ? '0 : idx + IDX_W'(1);
  assign tick      = (preCnt == prescLat);
  assign curLen    = phaseHigh ? tonLat : toffLat;
  assign lenM1     = (curLen == '0) ? '0 : curLen - DUR_W'(1);
  assign phaseEnd  = tick && (durCnt == lenM1);
  assign lastPulse = ((CNT_W'(idx) + CNT_W'(1)) == cntLat);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      tonLat    <= '0;
      toffLat   <= '0;
      cntLat    <= '0;
      prescLat  <= '0;
      phaseHigh <= 1'b0;
      preCnt    <= '0;
      durCnt    <= '0;
    end else if (strb.clear) begin
      idx       <= '0;
      phaseHigh <= 1'b0;
      preCnt    <= '0;
      durCnt    <= '0;
    end else begin
      if (strb.loadFirst) begin
        cntLat   <= cntClamp;
        prescLat <= prescale;
      end
      if (strb.loadFirst || strb.loadNext) begin
        idx       <= nextIdx;
        tonLat    <= tonArr[nextIdx];
        toffLat   <= toffArr[nextIdx];
        phaseHigh <= 1'b1;
        preCnt    <= '0;
        durCnt    <= '0;
      end else if (strb.toLow) begin
        phaseHigh <= 1'b0;
        preCnt    <= '0;
        durCnt    <= '0;
      end else if (strb.run) begin
        if (tick) begin
          preCnt <= '0;
          durCnt <= durCnt + DUR_W'(1);
        end else begin
          preCnt <= preCnt + PRESC_W'(1);
        end
      end
    end
  end

  // R3 R4 R5
  dur_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (durCnt <= lenM1));

  // R6
  presc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (preCnt <= prescLat));

  // R9
  count_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (cntLat <= CNT_W'(NUM_PULSES) && cntLat != '0));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (CNT_W'(idx) < cntLat));

endmodule

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
  import ptg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        abort,
  input  logic        countZero,
  input  logic        phaseEnd,
  input  logic        lastPulse,
  output ptg_strobe_t strb,
  output logic        pulseOut,
  output logic        busy,
  output logic        done
);

  ptg_state_e state;

  always_comb begin
    strb           = '0;
    strb.run       = (state != ST_IDLE);
    strb.loadFirst = (state == ST_IDLE) && start && !countZero && !abort && !rst;
    strb.toLow     = (state == ST_HIGH) && phaseEnd && !abort;
    strb.loadNext  = (state == ST_LOW) && phaseEnd && !lastPulse && !abort;
    strb.clear     = rst || abort || ((state == ST_LOW) && phaseEnd && lastPulse);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (countZero) done  <= 1'b1;
            else           state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (phaseEnd) state <= ST_LOW;
        end
        ST_LOW: begin
          if (phaseEnd) begin
            if (lastPulse) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_HIGH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pulseOut = (state == ST_HIGH);
  assign busy     = (state != ST_IDLE);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE));

  // R4
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW) |-> ($past(state) == ST_HIGH || $past(state) == ST_LOW));

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
  import ptg_pkg::*;
#(
  parameter int NUM_PULSES = 32,
  parameter int DUR_W      = 12,
  parameter int PRESC_W    = 8,
  localparam int WORD_W    = 2 * DUR_W,
  localparam int IDX_W     = $clog2(NUM_PULSES),
  localparam int CNT_W     = $clog2(NUM_PULSES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         abort,
  input  logic [CNT_W-1:0]             pulseCount,
  input  logic [PRESC_W-1:0]           prescale,
  input  logic [NUM_PULSES*WORD_W-1:0] cfgWords,
  output logic                         pulseOut,
  output logic [IDX_W-1:0]             pulseIdx,
  output logic                         busy,
  output logic                         done
);

  ptg_strobe_t strb;
  logic        countZero, phaseEnd, lastPulse;

  ptg_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .countZero (countZero),
    .phaseEnd  (phaseEnd),
    .lastPulse (lastPulse),
    .strb      (strb),
    .pulseOut  (pulseOut),
    .busy      (busy),
    .done      (done)
  );

  ptg_dpath #(
    .NUM_PULSES (NUM_PULSES),
    .DUR_W      (DUR_W),
    .PRESC_W    (PRESC_W)
  ) uDpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .pulseCount (pulseCount),
    .prescale   (prescale),
    .cfgWords   (cfgWords),
    .idx        (pulseIdx),
    .countZero  (countZero),
    .phaseEnd   (phaseEnd),
    .lastPulse  (lastPulse)
  );

  // R11
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!pulseOut && pulseIdx == '0 && !busy && !done));

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !abort && pulseCount == '0) |=> (done && !busy));

endmodule

// File: tb/pulse_train_gen_test.sv
module pulse_train_gen_test;

  localparam int NP = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic            abort = 1'b0;
  logic [5:0]      pulseCount = '0;
  logic [7:0]      prescale = '0;
  logic [23:0]     cfgMem [NP];
  logic [NP*24-1:0] cfgFlat;
  logic            pulseOut, busy, done;
  logic [4:0]      pulseIdx;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) cfgFlat[i*24 +: 24] = cfgMem[i];
  end

  pulse_train_gen uut (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .pulseCount(pulseCount), .prescale(prescale), .cfgWords(cfgFlat),
    .pulseOut(pulseOut), .pulseIdx(pulseIdx), .busy(busy), .done(done)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    checking = 0;
  bit    finished = 0;
  string curReq = "R1";

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase lengths kept as remaining-cycle budgets
  int mSt = 0, mIdx = 0, mEc = 0, mP = 0, mRemain = 0, mToff = 0;
  bit mDone = 0;

  function automatic int lenOf(int f);
    return (f == 0) ? 1 : f;
  endfunction

  task automatic loadPulse(int i);
    mRemain = lenOf(int'(cfgMem[i][11:0])) * (mP + 1);
    mToff   = lenOf(int'(cfgMem[i][23:12]));
  endtask

  always @(posedge clk) begin
    if (rst || abort) begin
      mSt = 0; mIdx = 0; mDone = 0; mRemain = 0;
    end else begin
      mDone = 0;
      case (mSt)
        0: if (start) begin
             if (pulseCount == 0) mDone = 1;
             else begin
               mEc = (pulseCount > NP) ? NP : int'(pulseCount);
               mP = int'(prescale); mIdx = 0; mSt = 1; loadPulse(0);
             end
           end
        1: if (mRemain == 1) begin mSt = 2; mRemain = mToff * (mP + 1); end
           else mRemain--;
        default: if (mRemain == 1) begin
             if (mIdx == mEc - 1) begin mSt = 0; mDone = 1; mIdx = 0; end
             else begin mIdx++; mSt = 1; loadPulse(mIdx); end
           end else mRemain--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      check(curReq, "pulseOut", int'(pulseOut), (mSt == 1) ? 1 : 0);
      check(curReq, "pulseIdx", int'(pulseIdx), mIdx);
      check(curReq, "busy", int'(busy), (mSt != 0) ? 1 : 0);
      check(curReq, "done", int'(done), int'(mDone));
    end
  end

  task automatic setWord(int i, int ton, int toff);
    cfgMem[i] = {12'(toff), 12'(ton)};
  endtask

  task automatic kick(int cnt, int p);
    @(negedge clk);
    pulseCount = 6'(cnt); prescale = 8'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (mSt == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NP; i++) setWord(i, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pulseOut", int'(pulseOut), 0);
    check("R1", "pulseIdx", int'(pulseIdx), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    rst = 1'b0;
    checking = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R7: three distinct pulses, prescale 0
    curReq = "R2 R3 R4 R7";
    setWord(0, 2, 1); setWord(1, 3, 4); setWord(2, 1, 2);
    kick(3, 0);
    waitIdle();

    // R8: zero count
    curReq = "R8";
    kick(0, 0);
    repeat (2) @(negedge clk);

    // R5: zero-length fields
    curReq = "R5";
    setWord(0, 0, 0); setWord(1, 0, 5);
    kick(2, 0);
    waitIdle();

    // R6: prescale 2, inputs changed mid-burst
    curReq = "R6";
    setWord(0, 3, 2); setWord(1, 1, 4);
    kick(2, 2);
    prescale = 8'd7; pulseCount = 6'd9;
    waitIdle();

    // R12: words changed during a pulse
    curReq = "R12";
    setWord(0, 6, 2); setWord(1, 2, 2); setWord(2, 1, 1);
    kick(3, 0);
    repeat (2) @(negedge clk);
    setWord(0, 1, 9);
    setWord(1, 9, 3);
    waitIdle();

    // R10: start while busy ignored
    curReq = "R10";
    setWord(0, 4, 4); setWord(1, 2, 2);
    kick(2, 0);
    repeat (3) @(negedge clk);
    pulseCount = 6'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();

    // R11: abort mid-burst, then abort together with start
    curReq = "R11";
    setWord(0, 5, 5);
    kick(3, 1);
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check("R11", "pulseOut after abort", int'(pulseOut), 0);
    check("R11", "busy after abort", int'(busy), 0);
    pulseCount = 6'd2; start = 1'b1; abort = 1'b1;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    check("R11", "busy after abort+start", int'(busy), 0);
    repeat (3) @(negedge clk);

    // R9: count above limit clamps to 32
    curReq = "R9";
    for (int i = 0; i < NP; i++) setWord(i, (i % 3) + 1, (i % 2) + 1);
    kick(40, 0);
    waitIdle();

    checking = 0;
    finishRun();
  end

endmodule